// File: doc/BRIEF.md
# Quad SPI Instruction Sequencer

This block drives a serial flash over chip select, a serial clock and four data lines by running small programs held in a writable table. The table holds 16 sequences. Each sequence has 8 slots, and each slot holds one 16-bit micro-instruction. An instruction names an action, the number of data lines to use for it, and an 8-bit argument. The supported actions are send a command byte, send a mode byte, wait idle clocks, read data, write data, and stop.

Software fills the table with 32-bit word writes. It then starts a transfer by writing a trigger word, which carries a sequence number and a byte count. The engine steps through the slots in order. Write data is pulled from a valid/ready byte stream, and read data is pushed out as a byte stream with a valid strobe. When the sequence ends, the engine sets a completion flag, which can raise an interrupt.

The serial clock runs at half the core clock. Each bit period, called a beat here, lasts two core cycles: the serial clock is low in the first and high in the second. The engine drives outgoing data for the whole beat. It samples incoming data at the core edge that ends the high half. The four data lines are split into input, output and output-enable vectors, so the pad ring can build the bidirectional pins.

Top module: `qspi_seq_engine`

## Requirements
- R1: Table word W holds slots 2k (bits 15:0) and 2k+1 (bits 31:16) of sequence W/4, with k = W mod 4. The engine runs the slots of the triggered sequence from slot 0 upward.
- R2: In each instruction, the opcode sits in bits 15:10, the line-width code in bits 9:8 and the argument in bits 7:0. Opcode 1 (command) and opcode 4 (mode) send the argument MSB first. Width code 0 sends one bit per beat on line 0. Width code 1 sends two bits per beat on lines 1:0, with the higher bit on line 1. Width code 2 sends four bits per beat on lines 3:0. Only the lines in use have their output enable set.
- R3: Opcode 3 inserts as many beats as its argument, with every output enable low. An argument of 0 inserts no beats. Arguments above 64 insert 64 beats.
- R4: Opcode 7 reads as many bytes as the trigger count. The lines follow the width code, except that single-line reads sample line 1. Bits are gathered MSB first. Each finished byte appears on rx_data with a one-cycle rx_valid pulse. All output enables stay low while reading.
- R5: Opcode 8 takes as many bytes as the trigger count from the transmit stream. It accepts a byte only when tx_valid and tx_ready are both high. Each byte is sent as in R2, and the serial clock pauses while no byte is offered.
- R6: Opcode 0 ends the sequence. Finishing slot 7 without meeting opcode 0 also ends it. When a sequence ends, cs_n goes high, busy falls and done is set, all on the same edge.
- R7: done stays set until a cycle with done_clr high. irq equals done AND irq_en.
- R8: A trigger word holds the sequence number in bits 27:24 and the byte count in bits 15:0. busy is high from the edge after an accepted trigger until the sequence ends. Triggers that arrive while busy are ignored.
- R9: After reset, cs_n is high, and sck, busy, done, irq, rx_valid and every output enable are low. Whenever the engine is idle, cs_n is high and sck is low. cs_n stays low for the whole sequence.
- R10: A read or write with a trigger count of 0 produces no beats, and the engine moves on to the next slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_we | input | 1 | Table word write strobe |
| tbl_addr | input | 6 | Table word index |
| tbl_wdata | input | 32 | Table word, two instructions |
| trig_we | input | 1 | Trigger write strobe |
| trig_word | input | 32 | Sequence number [27:24], byte count [15:0] |
| irq_en | input | 1 | Interrupt enable for done |
| done_clr | input | 1 | Write-one clear of done |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence finished flag |
| irq | output | 1 | Interrupt request |
| tx_data | input | 8 | Transmit byte |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Transmit byte taken this cycle when valid |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | Received byte strobe |
| cs_n | output | 1 | Flash chip select, active low |
| sck | output | 1 | Serial clock |
| io_out | output | 4 | Data line output values |
| io_oe | output | 4 | Data line output enables |
| io_in | input | 4 | Data line input values |

## Verification
The hardest cases to reach are trigger writes that land in the middle of a long sequence, and dummy arguments beyond the 64-beat cap. A trigger in mid-sequence is only possible while the serial lines are busy, and an oversized dummy argument only shows up as a missing tail of clock pulses. The bench uses a fixed seed to draw random sequences, in which every slot gets a random action, line width and argument, with dummy arguments drawn up to 70. It mixes these with directed runs that retrigger in mid-sequence, fill all eight slots without a stop, and use a byte count of zero. Each run is scored beat by beat against an expected trace built from the table contents. A bench model of the flash drives the read lines with a pattern that depends on the beat index.

// File: rtl/qspi_seq_pkg.sv
package qspi_seq_pkg;

   localparam logic [5:0] OP_STOP  = 6'd0;
   localparam logic [5:0] OP_CMD   = 6'd1;
   localparam logic [5:0] OP_DUMMY = 6'd3;
   localparam logic [5:0] OP_MODE  = 6'd4;
   localparam logic [5:0] OP_READ  = 6'd7;
   localparam logic [5:0] OP_WRITE = 6'd8;

   typedef struct packed {
      logic [5:0] op;
      logic [1:0] width;
      logic [7:0] arg;
   } uinstr_t;

   typedef enum logic [2:0] {
      ST_IDLE, ST_FETCH, ST_TXWAIT, ST_SHIFT, ST_DUMMY, ST_END
   } eng_state_e;

   function automatic logic [3:0] beats_per_byte(input logic [1:0] width);
      case (width)
         2'd0:    return 4'd8;
         2'd1:    return 4'd4;
         default: return 4'd2;
      endcase
   endfunction

endpackage

// File: rtl/qspi_seq_table.sv
module qspi_seq_table #(
   parameter int SEQS  = 16,
   parameter int SLOTS = 8
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             wr_en,
   input  logic [$clog2(SEQS*SLOTS/2)-1:0]  wr_addr,
   input  logic [31:0]                      wr_data,
   input  logic [$clog2(SEQS)-1:0]          rd_seq,
   input  logic [$clog2(SLOTS)-1:0]         rd_slot,
   output logic [15:0]                      rd_instr
);
   localparam int WORDS  = SEQS * SLOTS / 2;
   localparam int SLOT_W = $clog2(SLOTS);

   logic [31:0] words [WORDS];
   logic [31:0] sel_word;

   for (genvar w = 0; w < WORDS; w++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            words[w] <= '0;
         else if (wr_en && (wr_addr == w[$clog2(WORDS)-1:0]))
            words[w] <= wr_data;
      end
   end

   // sequence N starts at word N*(SLOTS/2); slot pairs share a word
   assign sel_word = words[{rd_seq, rd_slot[SLOT_W-1:1]}];
   assign rd_instr = rd_slot[0] ? sel_word[31:16] : sel_word[15:0];

endmodule

// File: rtl/qspi_lane_shift.sv
module qspi_lane_shift (
   input  logic [7:0] sreg,
   input  logic [1:0] width,
   input  logic [3:0] io_in,
   output logic [3:0] lane_out,
   output logic [3:0] lane_oe,
   output logic [7:0] sreg_next
);
   logic [3:0] cand_out [3];
   logic [3:0] cand_oe  [3];
   logic [7:0] cand_nxt [3];

   for (genvar g = 0; g < 3; g++) begin : g_lanes
      localparam int W = 1 << g;
      assign cand_out[g] = 4'(sreg[7 -: W]);
      assign cand_oe[g]  = 4'((1 << W) - 1);
      if (g == 0) begin : g_single
         // single-line reads come back on line 1
         assign cand_nxt[g] = {sreg[6:0], io_in[1]};
      end else begin : g_multi
         assign cand_nxt[g] = {sreg[7-W:0], io_in[W-1:0]};
      end
   end

   logic [1:0] sel;
   assign sel       = (width == 2'd0) ? 2'd0 : (width == 2'd1) ? 2'd1 : 2'd2;
   assign lane_out  = cand_out[sel];
   assign lane_oe   = cand_oe[sel];
   assign sreg_next = cand_nxt[sel];

endmodule

// File: rtl/qspi_seq_engine.sv
module qspi_seq_engine #(
   parameter int SEQS      = 16,
   parameter int SLOTS     = 8,
   parameter int CNT_W     = 16,
   parameter int DUMMY_MAX = 64,
   parameter int TBL_AW    = $clog2(SEQS*SLOTS/2)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tbl_we,
   input  logic [TBL_AW-1:0] tbl_addr,
   input  logic [31:0]       tbl_wdata,
   input  logic              trig_we,
   input  logic [31:0]       trig_word,
   input  logic              irq_en,
   input  logic              done_clr,
   output logic              busy,
   output logic              done,
   output logic              irq,
   input  logic [7:0]        tx_data,
   input  logic              tx_valid,
   output logic              tx_ready,
   output logic [7:0]        rx_data,
   output logic              rx_valid,
   output logic              cs_n,
   output logic              sck,
   output logic [3:0]        io_out,
   output logic [3:0]        io_oe,
   input  logic [3:0]        io_in
);
   import qspi_seq_pkg::*;

   localparam int SEQ_W  = $clog2(SEQS);
   localparam int SLOT_W = $clog2(SLOTS);
   localparam logic [7:0] DMAX_V = 8'(DUMMY_MAX);
   localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);

   if ((SLOTS % 2) != 0 || (1 << SLOT_W) != SLOTS) begin : g_bad_slots
      $error("SLOTS must be an even power of two");
   end
   if ((1 << SEQ_W) != SEQS || SEQ_W > 8) begin : g_bad_seqs
      $error("SEQS must be a power of two up to 256");
   end
   if (CNT_W > 24 || DUMMY_MAX > 255 || DUMMY_MAX < 1) begin : g_bad_misc
      $error("CNT_W must fit below bit 24 and DUMMY_MAX in 1..255");
   end
   if (TBL_AW != SEQ_W + SLOT_W - 1) begin : g_bad_aw
      $error("TBL_AW must match the table depth");
   end

   eng_state_e        state;
   logic [SEQ_W-1:0]  seq_r;
   logic [SLOT_W-1:0] slot_r;
   logic [CNT_W-1:0]  cnt_r, bytes_r;
   logic [5:0]        op_r;
   logic [1:0]        width_r;
   logic [7:0]        sreg;
   logic [3:0]        beats_r;
   logic [7:0]        dleft_r;
   logic              ph;
   uinstr_t           ins;
   logic [3:0]        lane_out, lane_oe;
   logic [7:0]        sreg_next;
   logic              drive;

   qspi_seq_table #(.SEQS(SEQS), .SLOTS(SLOTS)) u_table (
      .clk(clk), .rst_n(rst_n),
      .wr_en(tbl_we), .wr_addr(tbl_addr), .wr_data(tbl_wdata),
      .rd_seq(seq_r), .rd_slot(slot_r), .rd_instr(ins)
   );

   qspi_lane_shift u_lanes (
      .sreg(sreg), .width(width_r), .io_in(io_in),
      .lane_out(lane_out), .lane_oe(lane_oe), .sreg_next(sreg_next)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         seq_r    <= '0;
         slot_r   <= '0;
         cnt_r    <= '0;
         bytes_r  <= '0;
         op_r     <= OP_STOP;
         width_r  <= '0;
         sreg     <= '0;
         beats_r  <= '0;
         dleft_r  <= '0;
         ph       <= 1'b0;
         cs_n     <= 1'b1;
         done     <= 1'b0;
         rx_valid <= 1'b0;
         rx_data  <= '0;
      end else begin
         rx_valid <= 1'b0;
         if (done_clr)
            done <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (trig_we) begin
                  seq_r  <= trig_word[24 +: SEQ_W];
                  cnt_r  <= trig_word[CNT_W-1:0];
                  slot_r <= '0;
                  cs_n   <= 1'b0;
                  state  <= ST_FETCH;
               end
            end
            ST_FETCH: begin
               op_r    <= ins.op;
               width_r <= ins.width;
               ph      <= 1'b0;
               case (ins.op)
                  OP_STOP: state <= ST_END;
                  OP_CMD, OP_MODE: begin
                     sreg    <= ins.arg;
                     beats_r <= beats_per_byte(ins.width);
                     state   <= ST_SHIFT;
                  end
                  OP_DUMMY: begin
                     if (ins.arg == 8'd0) begin
                        slot_r <= slot_r + 1'b1;
                        state  <= (slot_r == LAST_SLOT) ? ST_END : ST_FETCH;
                     end else begin
                        dleft_r <= (ins.arg > DMAX_V) ? DMAX_V : ins.arg;
                        state   <= ST_DUMMY;
                     end
                  end
                  OP_READ, OP_WRITE: begin
                     if (cnt_r == '0) begin
                        slot_r <= slot_r + 1'b1;
                        state  <= (slot_r == LAST_SLOT) ? ST_END : ST_FETCH;
                     end else begin
                        bytes_r <= cnt_r;
                        beats_r <= beats_per_byte(ins.width);
                        state   <= (ins.op == OP_READ) ? ST_SHIFT : ST_TXWAIT;
                     end
                  end
                  default: begin
                     slot_r <= slot_r + 1'b1;
                     state  <= (slot_r == LAST_SLOT) ? ST_END : ST_FETCH;
                  end
               endcase
            end
            ST_TXWAIT: begin
               if (tx_valid) begin
                  sreg    <= tx_data;
                  beats_r <= beats_per_byte(width_r);
                  ph      <= 1'b0;
                  state   <= ST_SHIFT;
               end
            end
            ST_SHIFT: begin
               ph <= ~ph;
               if (ph) begin
                  sreg    <= sreg_next;
                  beats_r <= beats_r - 1'b1;
                  if (beats_r == 4'd1) begin
                     if (op_r == OP_READ) begin
                        rx_valid <= 1'b1;
                        rx_data  <= sreg_next;
                     end
                     if ((op_r == OP_READ || op_r == OP_WRITE) && bytes_r != CNT_W'(1)) begin
                        bytes_r <= bytes_r - 1'b1;
                        beats_r <= beats_per_byte(width_r);
                        if (op_r == OP_WRITE)
                           state <= ST_TXWAIT;
                     end else begin
                        slot_r <= slot_r + 1'b1;
                        state  <= (slot_r == LAST_SLOT) ? ST_END : ST_FETCH;
                     end
                  end
               end
            end
            ST_DUMMY: begin
               ph <= ~ph;
               if (ph) begin
                  dleft_r <= dleft_r - 1'b1;
                  if (dleft_r == 8'd1) begin
                     slot_r <= slot_r + 1'b1;
                     state  <= (slot_r == LAST_SLOT) ? ST_END : ST_FETCH;
                  end
               end
            end
            ST_END: begin
               cs_n  <= 1'b1;
               done  <= 1'b1;
               state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign drive    = (state == ST_SHIFT) && (op_r != OP_READ);
   assign io_out   = drive ? lane_out : 4'b0000;
   assign io_oe    = drive ? lane_oe : 4'b0000;
   assign sck      = ph;
   assign busy     = (state != ST_IDLE);
   assign tx_ready = (state == ST_TXWAIT);
   assign irq      = done & irq_en;

   // R9
   idle_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE) |-> (cs_n && !sck));

   // R3
   dummy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_DUMMY) |-> (io_oe == 4'b0000));

   // R4
   rx_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> (op_r == OP_READ && io_oe == 4'b0000 && !cs_n));

   // R8
   retrigger_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && trig_we) |=> $stable(seq_r) && $stable(cnt_r));

   // R7
   done_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && done_clr && state != ST_END) |=> !done);

   // R6
   finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> (cs_n && !busy));

   // R2
   lane_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (io_oe != 4'b0000) |-> ($countones(io_oe) == 1 || $countones(io_oe) == 2
                              || $countones(io_oe) == 4));

endmodule

// File: tb/sim_qspi_seq_engine.sv
`timescale 1ns/1ps
module sim_qspi_seq_engine;
   localparam logic [5:0] K_STOP = 6'd0, K_CMD = 6'd1, K_DUMMY = 6'd3,
                          K_MODE = 6'd4, K_READ = 6'd7, K_WRITE = 6'd8;

   logic clk = 1'b0, rst_n = 1'b0;
   logic tbl_we = 1'b0; logic [5:0] tbl_addr = '0; logic [31:0] tbl_wdata = '0;
   logic trig_we = 1'b0; logic [31:0] trig_word = '0;
   logic irq_en = 1'b0, done_clr = 1'b0;
   logic busy, done, irq, tx_ready, rx_valid, cs_n, sck;
   logic [7:0] tx_data = '0, rx_data;
   logic tx_valid = 1'b0;
   logic [3:0] io_out, io_oe, io_in = '0;

   qspi_seq_engine u0 (
      .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_wdata(tbl_wdata),
      .trig_we(trig_we), .trig_word(trig_word), .irq_en(irq_en), .done_clr(done_clr),
      .busy(busy), .done(done), .irq(irq), .tx_data(tx_data), .tx_valid(tx_valid),
      .tx_ready(tx_ready), .rx_data(rx_data), .rx_valid(rx_valid), .cs_n(cs_n), .sck(sck),
      .io_out(io_out), .io_oe(io_oe), .io_in(io_in)
   );

   always #2.5 clk = ~clk;

   int n_cmp = 0, n_bad = 0, cyc = 0;
   logic [15:0] model [16][8];
   logic [3:0] exp_out [1024]; logic [3:0] exp_oe [1024]; string exp_req [1024];
   int exp_n, exp_rx_n, tx_n;
   logic [7:0] exp_rx [256]; logic [7:0] txq [256];
   logic [3:0] cap_out [1024]; logic [3:0] cap_oe [1024];
   logic [7:0] got_rx [256];
   int edge_n = 0, rx_n = 0, tx_idx = 0;
   logic prev_sck = 1'b0, pend = 1'b0;
   logic [3:0] salt = 4'h5;

   task automatic report;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         n_bad = n_bad + 1;
         $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
         report();
      end
   end

   function automatic logic [3:0] rdpat(input int e);
      return 4'((e * 7) ^ (e >> 2)) ^ salt;
   endfunction

   // flash-side model: records each rising sck, drives read data per beat
   always @(negedge clk) begin
      if (pend) tx_idx = tx_idx + 1;
      pend = tx_valid && tx_ready;
      if (sck && !prev_sck && edge_n < 1024) begin
         cap_out[edge_n] = io_out; cap_oe[edge_n] = io_oe;
         edge_n = edge_n + 1;
      end
      if (!sck) io_in = rdpat(edge_n);
      prev_sck = sck;
      if (rx_valid && rx_n < 256) begin got_rx[rx_n] = rx_data; rx_n = rx_n + 1; end
      tx_valid = (tx_idx < tx_n);
      tx_data  = txq[tx_idx % 256];
   end

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] expv);
      n_cmp = n_cmp + 1;
      if (got !== expv) begin
         n_bad = n_bad + 1;
         $display("FAIL %s: got %0h expected %0h", req, got, expv);
      end
   endtask

   task automatic put_instr(input int s, input int k, input logic [5:0] op,
                            input logic [1:0] w, input logic [7:0] a);
      model[s][k] = {op, w, a};
   endtask

   // R1: word s*4+j holds slot 2j low, slot 2j+1 high
   task automatic load_seq(input int s);
      for (int j = 0; j < 4; j++) begin
         @(negedge clk);
         tbl_we = 1'b1; tbl_addr = 6'(s * 4 + j);
         tbl_wdata = {model[s][2*j+1], model[s][2*j]};
      end
      @(negedge clk); tbl_we = 1'b0;
   endtask

   task automatic push_beat(input logic [3:0] o, input logic [3:0] oe, input string r);
      exp_out[exp_n] = o; exp_oe[exp_n] = oe; exp_req[exp_n] = r; exp_n = exp_n + 1;
   endtask

   task automatic push_byte(input logic [7:0] b, input int L, input string r);
      for (int k = 0; k < 8 / L; k++)
         push_beat(4'((b >> (8 - L * (k + 1))) & ((1 << L) - 1)), 4'((1 << L) - 1), r);
   endtask

   task automatic build_expected(input int s, input int cnt);
      exp_n = 0; exp_rx_n = 0; tx_n = 0;
      for (int k = 0; k < 8; k++) begin
         logic [5:0] op; logic [1:0] w; logic [7:0] a; int L;
         {op, w, a} = model[s][k];
         if (op == K_STOP) break;
         L = (w == 2'd0) ? 1 : (w == 2'd1) ? 2 : 4;
         if (op == K_CMD || op == K_MODE) push_byte(a, L, "R2");
         else if (op == K_DUMMY) begin
            for (int d = 0; d < ((a > 64) ? 64 : int'(a)); d++) push_beat(4'h0, 4'h0, "R3");
         end else if (op == K_READ) begin
            for (int b = 0; b < cnt; b++) begin
               logic [7:0] by = '0;
               for (int t = 0; t < 8 / L; t++) begin
                  logic [3:0] p = rdpat(exp_n);
                  by = (L == 1) ? {by[6:0], p[1]} : (L == 2) ? {by[5:0], p[1:0]} : {by[3:0], p};
                  push_beat(4'h0, 4'h0, "R4");
               end
               exp_rx[exp_rx_n] = by; exp_rx_n = exp_rx_n + 1;
            end
         end else if (op == K_WRITE) begin
            for (int b = 0; b < cnt; b++) begin
               txq[tx_n] = 8'($urandom); push_byte(txq[tx_n], L, "R5"); tx_n = tx_n + 1;
            end
         end
      end
   endtask

   // runs sequence s; if retrig>0, fires a trigger for seq 3 that many cycles in
   task automatic run_seq(input int s, input int cnt, input int retrig);
      build_expected(s, cnt);
      @(negedge clk);
      edge_n = 0; rx_n = 0; tx_idx = 0; pend = 1'b0;
      trig_word = {4'h0, 4'(s), 8'h00, 16'(cnt)}; trig_we = 1'b1;
      @(negedge clk); trig_we = 1'b0;
      check("R8 busy after trigger", 32'(busy), 32'd1);
      check("R9 cs_n low in sequence", 32'(cs_n), 32'd0);
      if (retrig > 0) begin
         repeat (retrig) @(negedge clk);
         trig_word = {8'h03, 8'h00, 16'd1}; trig_we = 1'b1;
         @(negedge clk); trig_we = 1'b0;
      end
      for (int w = 0; w < 20000 && busy; w++) @(negedge clk);
      check("R6 beat count", 32'(edge_n), 32'(exp_n));
      for (int e = 0; e < exp_n && e < edge_n; e++) begin
         check(exp_req[e], 32'(cap_oe[e]), 32'(exp_oe[e]));
         if (exp_oe[e] != 0) check(exp_req[e], 32'(cap_out[e] & cap_oe[e]), 32'(exp_out[e]));
      end
      check("R4 rx byte count", 32'(rx_n), 32'(exp_rx_n));
      for (int b = 0; b < exp_rx_n && b < rx_n; b++) check("R4 rx byte", 32'(got_rx[b]), 32'(exp_rx[b]));
      check("R5 tx bytes taken", 32'(tx_idx), 32'(tx_n));
      check("R6 done set at end", 32'(done), 32'd1);
      check("R6 cs_n high at end", 32'(cs_n), 32'd1);
      @(negedge clk); done_clr = 1'b1; @(negedge clk); done_clr = 1'b0;
      check("R7 done cleared", 32'(done), 32'd0);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      for (int s = 0; s < 16; s++) for (int k = 0; k < 8; k++) model[s][k] = '0;
      repeat (3) @(negedge clk);
      // R9 reset state
      check("R9 cs_n reset", 32'(cs_n), 32'd1);
      check("R9 sck reset", 32'(sck), 32'd0);
      check("R9 busy reset", 32'(busy), 32'd0);
      check("R9 done/irq reset", 32'({done, irq, rx_valid}), 32'd0);
      check("R9 oe reset", 32'(io_oe), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // directed: R1 last sequence, mixed widths
      put_instr(15, 0, K_CMD, 2'd0, 8'hA5); put_instr(15, 1, K_MODE, 2'd2, 8'h3C);
      put_instr(15, 2, K_DUMMY, 2'd0, 8'd5); put_instr(15, 3, K_READ, 2'd1, 8'd0);
      put_instr(15, 4, K_READ, 2'd0, 8'd0); put_instr(15, 5, K_STOP, 2'd0, 8'd0);
      load_seq(15); run_seq(15, 3, 0);

      // R5 quad write
      put_instr(4, 0, K_CMD, 2'd1, 8'h6B); put_instr(4, 1, K_WRITE, 2'd2, 8'd0);
      put_instr(4, 2, K_STOP, 2'd0, 8'd0);
      load_seq(4); run_seq(4, 4, 0);

      // R6 eight slots with no stop
      for (int k = 0; k < 8; k++) put_instr(7, k, K_CMD, 2'(k % 3), 8'(8'h11 * k + 1));
      load_seq(7); run_seq(7, 0, 0);

      // R3 dummy cap and R10 zero count
      put_instr(9, 0, K_DUMMY, 2'd0, 8'd70); put_instr(9, 1, K_READ, 2'd2, 8'd0);
      put_instr(9, 2, K_WRITE, 2'd0, 8'd0); put_instr(9, 3, K_DUMMY, 2'd0, 8'd0);
      put_instr(9, 4, K_CMD, 2'd0, 8'h81); put_instr(9, 5, K_STOP, 2'd0, 8'd0);
      load_seq(9); run_seq(9, 0, 0);

      // R8 retrigger mid-sequence is ignored
      put_instr(2, 0, K_DUMMY, 2'd0, 8'd40); put_instr(2, 1, K_STOP, 2'd0, 8'd0);
      put_instr(3, 0, K_CMD, 2'd2, 8'hFF); put_instr(3, 1, K_STOP, 2'd0, 8'd0);
      load_seq(2); load_seq(3); run_seq(2, 0, 10);

      // R7 interrupt gating
      put_instr(5, 0, K_STOP, 2'd0, 8'd0); load_seq(5);
      @(negedge clk); trig_word = {8'h05, 24'd0}; trig_we = 1'b1;
      @(negedge clk); trig_we = 1'b0;
      repeat (4) @(negedge clk);
      check("R7 done without enable", 32'({done, irq}), 32'b10);
      irq_en = 1'b1; @(negedge clk);
      check("R7 irq with enable", 32'(irq), 32'd1);
      done_clr = 1'b1; @(negedge clk); done_clr = 1'b0;
      check("R7 irq cleared", 32'({done, irq}), 32'd0);
      irq_en = 1'b0;

      // random sequences
      for (int it = 0; it < 40; it++) begin
         int s, n, cnt;
         s = int'($urandom % 16); n = int'($urandom % 9); cnt = int'($urandom % 4);
         salt = 4'($urandom);
         for (int k = 0; k < 8; k++) begin
            int r; logic [5:0] op; logic [7:0] a;
            r = int'($urandom % 5); a = 8'($urandom);
            op = (r == 0) ? K_CMD : (r == 1) ? K_MODE : (r == 2) ? K_DUMMY : (r == 3) ? K_READ : K_WRITE;
            if (op == K_DUMMY) a = 8'(1 + $urandom % 70);
            if (k < n) put_instr(s, k, op, 2'($urandom % 3), a);
            else put_instr(s, k, K_STOP, 2'd0, 8'd0);
         end
         load_seq(s); run_seq(s, cnt, 0);
      end
      report();
   end
endmodule